// File: doc/BRIEF.md
# Page-Buffered Write Commit Controller

This block sits behind a serial slave front end and in front of a byte-wide storage array. When the front end reports that a write transaction has been selected, the block captures the word address. It then gathers the data bytes that follow into a small page buffer. The bytes are not written to the array while they arrive. They are committed only when the transaction ends with a STOP.

The commit runs as a self-timed program window of a fixed number of clock cycles. While the window runs, the block raises a busy flag, and the front end uses that flag to stop answering its selection address. Inside the window, the buffered bytes are copied into the array one per cycle. A hardware write-protect input is sampled at the STOP. When it is high, the bytes are still taken and acknowledged, but nothing is committed and no busy window starts.

A new start or an abort before the STOP throws away everything collected so far. The array is a behavioural register file inside the block, and it has a read port for the surrounding logic.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, busy, ack and arr_we are 0, and every array location reads 0.
- R2: A wr_start pulse while busy is 0 is accepted, and ack is 1 in the cycle after it. Each byte_valid pulse inside an open transaction is also acknowledged with ack in the next cycle. A byte_valid pulse with no open transaction gets no ack.
- R3: Byte k of a transaction (counting from 0) goes to the address whose bits [6:4] equal those of wr_addr and whose bits [3:0] equal (wr_addr[3:0] + k) mod 16. The low bits wrap inside the 16-byte page, and the upper bits never change.
- R4: When more than 16 bytes arrive, each later byte replaces the earlier byte that maps to the same slot. The array ends up holding the last byte sent for each slot.
- R5: A stop_evt that ends a transaction with at least one byte, while wp is 0, makes busy 1 from the next cycle. Busy stays 1 for exactly PROG_CYCLES cycles. Afterwards the array holds the buffered bytes, and locations that were not written keep their old values.
- R6: If wp is 1 when stop_evt arrives, busy stays 0 and the array is unchanged, even though every byte of the transaction was acknowledged.
- R7: An abort_evt, or a fresh wr_start, before the STOP discards the buffer. After an abort, a STOP starts no busy window. After a restart, only the bytes sent after the restart are committed, at the new address.
- R8: While busy is 1, wr_start and byte_valid get no ack and have no effect on the array.
- R9: A stop_evt after an address with no data bytes, or a stop_evt with no transaction open, starts no busy window.
- R10: arr_we is 1 only while busy is 1. It writes at most one byte per cycle, and only for slots that received a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write transaction selected (one-cycle strobe) |
| wr_addr | input | 7 | Word address captured with wr_start |
| byte_valid | input | 1 | Data byte received (one-cycle strobe) |
| byte_data | input | 8 | Data byte qualified by byte_valid |
| stop_evt | input | 1 | STOP seen on the bus (one-cycle strobe) |
| abort_evt | input | 1 | Transaction aborted (one-cycle strobe) |
| wp | input | 1 | Hardware write protect, 1 blocks commits |
| busy | output | 1 | Program window running |
| ack | output | 1 | Acknowledge for the previous cycle's accepted strobe |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
The ack for an accepted strobe comes one clock after that strobe, so the bench drives each strobe on a falling edge and reads ack on the next falling edge. Busy rises one clock after the STOP strobe, and the bench checks it at the same next falling edge. It then counts the falling edges on which busy is still high and compares that count with PROG_CYCLES. Array contents are compared through the combinational read port only after busy has fallen, against a model computed from the address arithmetic of R3 and R4.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_BYTES-1:0] fill_mask
);
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s]    <= '0;
        fill_mask[s] <= 1'b0;
      end else begin
        if (hit) slot_q[s] <= wr_data;
        if (clr) fill_mask[s] <= 1'b0;
        else if (hit) fill_mask[s] <= 1'b1;
      end
    end
  end

  assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 40,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             running,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic             run_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    run_d = running;
    cnt_d = elapsed;
    if (launch && !running) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (running) begin
      if (elapsed == LAST) run_d = 1'b0;
      else                 cnt_d = elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      elapsed <= '0;
    end else begin
      running <= run_d;
      elapsed <= cnt_d;
    end
  end

  // R5
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(elapsed) == LAST);
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cell_q[a] <= '0;
      else if (we && waddr == AW'(a))     cell_q[a] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int PAGE_BYTES  = 16,
  parameter int ARRAY_BYTES = 128,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 40,
  localparam int AW         = $clog2(ARRAY_BYTES),
  localparam int SLOT_W     = $clog2(PAGE_BYTES),
  localparam int PG_W       = AW - SLOT_W,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [AW-1:0]     wr_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              abort_evt,
  input  logic              wp,
  output logic              busy,
  output logic              ack,
  output logic              arr_we,
  output logic [AW-1:0]     arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import eepc_pkg::*;

  ctl_state_e        state_q, state_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic              ack_d;
  logic              buf_clr, buf_wr, launch;
  logic [PAGE_BYTES-1:0] fill_mask;
  logic [CNT_W-1:0]  elapsed;
  logic [SLOT_W-1:0] scan_slot;
  logic [DATA_W-1:0] scan_data;
  logic              scan_live;

  // Next-state process
  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    ptr_d   = ptr_q;
    ack_d   = 1'b0;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_start && !busy) begin
          state_d = ST_COLLECT;
          page_d  = wr_addr[AW-1:SLOT_W];
          ptr_d   = wr_addr[SLOT_W-1:0];
          buf_clr = 1'b1;
          ack_d   = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (abort_evt) begin
          state_d = ST_IDLE;
        end else if (wr_start) begin
          page_d  = wr_addr[AW-1:SLOT_W];
          ptr_d   = wr_addr[SLOT_W-1:0];
          buf_clr = 1'b1;
          ack_d   = 1'b1;
        end else if (stop_evt) begin
          state_d = ST_IDLE;
          launch  = (|fill_mask) && !wp;
        end else if (byte_valid) begin
          buf_wr  = 1'b1;
          ptr_d   = ptr_q + 1'b1;
          ack_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      ack     <= 1'b0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      ptr_q   <= ptr_d;
      ack     <= ack_d;
    end
  end

  page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) i_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_slot  (ptr_q),
    .wr_data  (byte_data),
    .rd_slot  (scan_slot),
    .rd_data  (scan_data),
    .fill_mask(fill_mask)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .running(busy),
    .elapsed(elapsed)
  );

  // Commit scan: slot i is copied in elapsed cycle i of the window
  assign scan_slot = elapsed[SLOT_W-1:0];
  assign scan_live = busy && (elapsed < CNT_W'(PAGE_BYTES));
  assign arr_we    = scan_live && fill_mask[scan_slot];
  assign arr_addr  = {page_q, scan_slot};
  assign arr_wdata = scan_data;

  cell_array #(.DEPTH(ARRAY_BYTES), .DATA_W(DATA_W)) i_arr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (arr_we),
    .waddr(arr_addr),
    .wdata(arr_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // R10
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R5
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_evt) && !$past(wp)));

  // R8
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ack);

  // R7
  abort_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT && abort_evt) |=> !busy);

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT && stop_evt && wp) |=> !busy);
endmodule

// File: tb/test_eeprom_page_commit.sv
module test_eeprom_page_commit;
  localparam int PROG = 40;

  logic       clk, rst_n;
  logic       wr_start, byte_valid, stop_evt, abort_evt, wp;
  logic [6:0] wr_addr, arr_addr, rd_addr;
  logic [7:0] byte_data, arr_wdata, rd_data;
  logic       busy, ack, arr_we;

  int checks = 0;
  int fails  = 0;
  int stray_we = 0;
  logic [7:0] model [128];

  eeprom_page_commit #(.PROG_CYCLES(PROG)) i_eeprom_page_commit (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_evt(stop_evt),
    .abort_evt(abort_evt), .wp(wp), .busy(busy), .ack(ack), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R10: array writes must never appear outside the busy window
  always @(negedge clk) if (rst_n && arr_we && !busy) stray_we++;

  // vector: addr[21:15] n[14:10] seed[9:2] wp[1] abort[0]
  localparam logic [21:0] VECS [7] = '{
    {7'h12, 5'd3,  8'hA0, 1'b0, 1'b0},
    {7'h2E, 5'd5,  8'h10, 1'b0, 1'b0},
    {7'h40, 5'd18, 8'h50, 1'b0, 1'b0},
    {7'h70, 5'd4,  8'hC0, 1'b1, 1'b0},
    {7'h05, 5'd3,  8'h77, 1'b0, 1'b1},
    {7'h7F, 5'd1,  8'h33, 1'b0, 1'b0},
    {7'h30, 5'd0,  8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [6:0] a, output logic got);
    wr_start = 1'b1; wr_addr = a;
    @(negedge clk); got = ack; wr_start = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d, output logic got);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk); got = ack; byte_valid = 1'b0;
  endtask

  task automatic do_stop(output logic b);
    stop_evt = 1'b1;
    @(negedge clk); b = busy; stop_evt = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 10 * PROG) begin n++; @(negedge clk); end
  endtask

  task automatic cmp_array(input string req);
    int bad = 0; int first = -1;
    for (int i = 0; i < 128; i++) begin
      rd_addr = 7'(i); #0.1;
      if (rd_data !== model[i]) begin bad++; if (first < 0) first = i; end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else begin
      rd_addr = 7'(first); #0.1;
      chk(1'b0, req, int'(rd_data), int'(model[first]));
    end
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic g, b; int n;
    wr_start = 0; byte_valid = 0; stop_evt = 0; abort_evt = 0; wp = 0;
    wr_addr = 0; byte_data = 0; rd_addr = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && ack == 0 && arr_we == 0, "R1 outputs", {busy, ack, arr_we}, 0);
    cmp_array("R1 array cleared");

    // Table walk: R2 R3 R4 R5 R6 R7 R9
    foreach (VECS[v]) begin
      logic [6:0] a; int cnt; logic [7:0] sd; logic vp, ab; bit commit;
      a = VECS[v][21:15]; cnt = int'(VECS[v][14:10]); sd = VECS[v][9:2];
      vp = VECS[v][1]; ab = VECS[v][0];
      commit = !vp && !ab && cnt > 0;
      wp = vp;
      do_start(a, g);
      chk(g == 1'b1, "R2 start ack", g, 1);
      for (int k = 0; k < cnt; k++) begin
        do_byte(sd + 8'(k), g);
        chk(g == 1'b1, "R2 byte ack", g, 1);
        if (commit) model[{a[6:4], 4'(a[3:0] + 4'(k))}] = sd + 8'(k);
      end
      if (ab) begin
        abort_evt = 1'b1; @(negedge clk); abort_evt = 1'b0;
      end
      do_stop(b);
      chk(b == commit, commit ? "R5 busy rises" : (vp ? "R6 wp no busy" : (ab ? "R7 abort no busy" : "R9 empty no busy")), b, commit);
      if (commit) begin
        busy_len(n);
        chk(n == PROG, "R5 window length", n, PROG);
      end
      wp = 1'b0;
      @(negedge clk);
      cmp_array(cnt > 16 ? "R4 wrap overwrite" : "R3 R5 R6 R7 array content");
    end

    // R7 restart discards earlier bytes
    do_start(7'h50, g);
    do_byte(8'h11, g); do_byte(8'h22, g);
    do_start(7'h63, g);
    chk(g == 1'b1, "R7 restart ack", g, 1);
    do_byte(8'h99, g);
    model[7'h63] = 8'h99;
    do_stop(b);
    chk(b == 1'b1, "R7 restart commit busy", b, 1);

    // R8 strobes during busy
    @(negedge clk);
    do_start(7'h00, g);
    chk(g == 1'b0, "R8 start ignored when busy", g, 0);
    do_byte(8'hEE, g);
    chk(g == 1'b0, "R8 byte ignored when busy", g, 0);
    busy_len(n);
    @(negedge clk);
    cmp_array("R7 R8 array after restart and busy strobes");

    // R2 / R9 strobes with no transaction open
    do_byte(8'h5A, g);
    chk(g == 1'b0, "R2 byte without start", g, 0);
    do_stop(b);
    chk(b == 1'b0, "R9 stray stop", b, 0);
    @(negedge clk);
    cmp_array("R9 array unchanged");

    chk(stray_we == 0, "R10 writes only while busy", stray_we, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule